// File: doc/BRIEF.md
# Debug Register Access Scan Chain

This block is a data-register chain that sits behind a test access port. It gives a debug host read and write access to a register space of 2^ADDR_W words of DATA_W bits. The host shifts a frame of DATA_W + ADDR_W + 1 bits through the chain. When the port signals the update, the block turns the frame into exactly one access on a simple register bus.

The most significant frame bit is the direction: 1 requests a write and 0 requests a read. The next ADDR_W bits, down to bit DATA_W, hold the register address. The low DATA_W bits carry write data on the way in and read data on the way out.

Reads are pipelined by one scan. A read fetches the addressed register into a holding latch. The next scan's capture copies that latch into the data field, so the value leaves the chain while the following request goes in. Every read is a real bus access and may have side effects, such as popping a stream register. To collect the last result of a stream, the host ends with a read of address 0, which is free of side effects.

The chain is only live when the instruction register holds the access code and a separate chain-select register holds the access chain number. The chain-select register is a short scan register of its own, reached under a second instruction code.

Top module: `dbg_reg_scan`

## Requirements
- R1: Frame layout (for the defaults, 40 bits):
  - bits 31:0 are data, bits 38:32 are the address and bit 39 is the direction flag.
  - During a shift, bits enter at `tdi` and leave at `tdo` least-significant bit first.
  - `tdo` shows frame bit i before the i-th shift edge.
- R2: An update whose direction flag is 1 raises `bus_req` for one cycle, in the cycle after the update strobe. In that cycle `bus_wr` is 1, and `bus_addr` and `bus_wdata` carry the frame's address and data.
- R3: An update whose direction flag is 0 raises `bus_req` for one cycle with `bus_wr` 0. The block samples `bus_rdata` one cycle after that request and keeps the value in its read latch.
- R4: A capture on the live chain loads the read latch into the data field and zeros into the address and flag bits. The data shifted out in a scan is therefore the result of the read requested in the previous scan.
- R5: A write access leaves the read latch unchanged, so the scan after a write still returns the last read result.
- R6: Each update on the live chain produces exactly one bus access. A register whose reads have side effects advances once per read request.
- R7: When the instruction is not the access code (default 4'hC), or the selected chain is not the access chain (default 0):
  - an update issues no bus access;
  - the access shift register holds its contents.
- R8: Chain-select register:
  - It is reached under instruction code 4'h2 and is SEL_W bits wide (default 5), shifted least-significant bit first.
  - A capture loads the current chain number into it.
  - An update makes its contents the new chain number.
  - After reset the chain number is all ones.
- R9: While reset is held, and in the cycle after it:
  - `bus_req` is 0;
  - `tdo` is 0;
  - the read latch is 0, so the first scan after reset returns zero data.
- R10: `tdo` depends on the instruction:
  - under the select code it carries the chain-select register;
  - under the access code with the access chain selected it carries the access frame;
  - otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the port-state strobes and the register bus |
| rst | input | 1 | Synchronous active-high reset |
| tap_ir | input | IR_W | Current instruction register value |
| tap_capture | input | 1 | One-cycle strobe: capture data register |
| tap_shift | input | 1 | Shift enable, one bit per cycle |
| tap_update | input | 1 | One-cycle strobe: update data register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bus_req | output | 1 | One-cycle register access strobe |
| bus_wr | output | 1 | 1 = write, 0 = read, valid with bus_req |
| bus_addr | output | ADDR_W | Register address, valid with bus_req |
| bus_wdata | output | DATA_W | Write data, valid with bus_req |
| bus_rdata | input | DATA_W | Read data, returned one cycle after a read request |

## Verification
The assertions check these properties on every cycle:
- an update on the live chain yields a bus strobe on the next cycle, and nothing else does;
- a capture places the latch value and a zero header in the frame;
- a write never disturbs the read latch;
- the shift register is frozen while the chain is not selected;
- a chain-select update commits the shifted value.

The one-scan read pipeline can only be shown by the bench's scan sequences, which compare every cycle against a behavioural model and a bus slave with a popping stream register. Those sequences cover data from a read surfacing one scan later, a write between two reads returning the older read, each stream read advancing the pointer exactly once, and the dummy address-0 read draining the last value.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_CAPTURE = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_UPDATE  = 2'd3
  } scan_op_e;

  // Capture wins over shift, shift over update; the port never raises two at once.
  function automatic scan_op_e decode_op(input logic cap, input logic shf, input logic upd);
    if (cap)      return OP_CAPTURE;
    else if (shf) return OP_SHIFT;
    else if (upd) return OP_UPDATE;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/dbg_scan_select.sv
module dbg_scan_select
  import dbg_scan_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             cap_i,
  input  logic             shf_i,
  input  logic             upd_i,
  input  logic             tdi_i,
  output logic [SEL_W-1:0] chain_o,
  output logic             tdo_o
);

  logic [SEL_W-1:0] sreg_q;
  logic [SEL_W-1:0] chain_q;
  scan_op_e         op;

  assign op = decode_op(cap_i, shf_i, upd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      chain_q <= '1;
    end else if (en_i) begin
      case (op)
        OP_CAPTURE: sreg_q  <= chain_q;
        OP_SHIFT:   sreg_q  <= {tdi_i, sreg_q[SEL_W-1:1]};
        OP_UPDATE:  chain_q <= sreg_q;
        default:    ;
      endcase
    end
  end

  assign chain_o = chain_q;
  assign tdo_o   = sreg_q[0];

  assert_sel_commit_R8: assert property (@(posedge clk) disable iff (rst)
    (en_i && upd_i && !cap_i && !shf_i) |=> (chain_q == $past(sreg_q)));

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(en_i && upd_i) |=> $stable(chain_q));

endmodule

// File: rtl/dbg_scan_frame.sv
module dbg_scan_frame
  import dbg_scan_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic               cap_i,
  input  logic               shf_i,
  input  logic               upd_i,
  input  logic               tdi_i,
  input  logic [DATA_W-1:0]  cap_data_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               tdo_o
);

  logic [FRAME_W-1:0] sh_q;
  scan_op_e           op;

  assign op = decode_op(cap_i, shf_i, upd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (en_i) begin
      case (op)
        OP_CAPTURE: sh_q <= {{(ADDR_W + 1){1'b0}}, cap_data_i};
        OP_SHIFT:   sh_q <= {tdi_i, sh_q[FRAME_W-1:1]};
        default:    ;
      endcase
    end
  end

  assign frame_o = sh_q;
  assign tdo_o   = sh_q[0];

  assert_capture_load_R4: assert property (@(posedge clk) disable iff (rst)
    (en_i && cap_i) |=> (sh_q[DATA_W-1:0] == $past(cap_data_i) &&
                          sh_q[FRAME_W-1:DATA_W] == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(sh_q));

endmodule

// File: rtl/dbg_scan_busctl.sv
module dbg_scan_busctl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bus_req_o,
  output logic               bus_wr_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [DATA_W-1:0]  bus_wdata_o,
  input  logic [DATA_W-1:0]  bus_rdata_i,
  output logic [DATA_W-1:0]  rd_latch_o
);

  logic              req_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_pend_q;
  logic [DATA_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q     <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rd_pend_q <= 1'b0;
      latch_q   <= '0;
    end else begin
      req_q     <= go_i;
      rd_pend_q <= req_q && !wr_q;
      if (go_i) begin
        wr_q    <= frame_i[FRAME_W-1];
        addr_q  <= frame_i[FRAME_W-2:DATA_W];
        wdata_q <= frame_i[DATA_W-1:0];
      end
      if (rd_pend_q) latch_q <= bus_rdata_i;
    end
  end

  assign bus_req_o   = req_q;
  assign bus_wr_o    = wr_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rd_latch_o  = latch_q;

  assert_one_access_R6: assert property (@(posedge clk) disable iff (rst)
    go_i |=> bus_req_o);

  assert_no_stray_access_R6: assert property (@(posedge clk) disable iff (rst)
    !go_i |=> !bus_req_o);

  assert_write_keeps_latch_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && bus_wr_o) ##1 !(bus_req_o && !bus_wr_o) |=> $stable(latch_q));

  assert_read_latched_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_req_o && !bus_wr_o) ##1 1'b1 |=> (latch_q == $past(bus_rdata_i)));

  assert_reset_idle_R9: assert property (@(posedge clk)
    rst |=> (!bus_req_o && latch_q == '0));

endmodule

// File: rtl/dbg_reg_scan.sv
module dbg_reg_scan
  import dbg_scan_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned IR_W         = 4,
  parameter int unsigned SEL_W        = 5,
  parameter logic [IR_W-1:0]  ACCESS_IR    = 4'hC,
  parameter logic [IR_W-1:0]  SELECT_IR    = 4'h2,
  parameter logic [SEL_W-1:0] ACCESS_CHAIN = '0,
  localparam int unsigned FRAME_W = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IR_W-1:0]   tap_ir,
  input  logic              tap_capture,
  input  logic              tap_shift,
  input  logic              tap_update,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic               sel_en;
  logic               acc_en;
  logic [SEL_W-1:0]   chain;
  logic               sel_tdo;
  logic               acc_tdo;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  rd_latch;
  logic               go;

  assign sel_en = (tap_ir == SELECT_IR);
  assign acc_en = (tap_ir == ACCESS_IR) && (chain == ACCESS_CHAIN);
  assign go     = acc_en && (decode_op(tap_capture, tap_shift, tap_update) == OP_UPDATE);

  dbg_scan_select #(.SEL_W(SEL_W)) u_select (
    .clk     (clk),
    .rst     (rst),
    .en_i    (sel_en),
    .cap_i   (tap_capture),
    .shf_i   (tap_shift),
    .upd_i   (tap_update),
    .tdi_i   (tdi),
    .chain_o (chain),
    .tdo_o   (sel_tdo)
  );

  dbg_scan_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .en_i       (acc_en),
    .cap_i      (tap_capture),
    .shf_i      (tap_shift),
    .upd_i      (tap_update),
    .tdi_i      (tdi),
    .cap_data_i (rd_latch),
    .frame_o    (frame),
    .tdo_o      (acc_tdo)
  );

  dbg_scan_busctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_busctl (
    .clk         (clk),
    .rst         (rst),
    .go_i        (go),
    .frame_i     (frame),
    .bus_req_o   (bus_req),
    .bus_wr_o    (bus_wr),
    .bus_addr_o  (bus_addr),
    .bus_wdata_o (bus_wdata),
    .bus_rdata_i (bus_rdata),
    .rd_latch_o  (rd_latch)
  );

  always_comb begin
    if (sel_en)      tdo = sel_tdo;
    else if (acc_en) tdo = acc_tdo;
    else             tdo = 1'b0;
  end

  assert_access_gated_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> ($past(tap_ir) == ACCESS_IR));

  assert_tdo_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (!sel_en && !acc_en) |-> !tdo);

endmodule

// File: tb/test_dbg_reg_scan.sv
`timescale 1ns/1ps
module test_dbg_reg_scan;

  localparam int DW = 32;
  localparam int AW = 7;
  localparam int FW = DW + AW + 1;
  localparam logic [31:0] ID_VAL = 32'h5EED_0042;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    tap_ir = 4'h0;
  logic          tap_capture = 1'b0, tap_shift = 1'b0, tap_update = 1'b0;
  logic          tdi = 1'b0;
  logic          tdo;
  logic          bus_req, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  int n_req = 0;

  always #2 clk = ~clk;

  dbg_reg_scan i_dbg_reg_scan (
    .clk(clk), .rst(rst), .tap_ir(tap_ir), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi), .tdo(tdo),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---- bus slave: plain registers, address 0 constant, address 4 pops ----
  logic [31:0] mem [128];
  logic [31:0] fifo_ptr = 32'd0;
  initial for (int i = 0; i < 128; i++) mem[i] = 32'h0101_0101 * i;

  always @(posedge clk) begin
    if (bus_req) begin
      n_req <= n_req + 1;
      if (bus_wr) begin
        if (bus_addr == 7'd4) fifo_ptr <= bus_wdata;
        else mem[bus_addr] <= bus_wdata;
      end else begin
        if (bus_addr == 7'd0) bus_rdata <= ID_VAL;
        else if (bus_addr == 7'd4) begin
          bus_rdata <= fifo_ptr;
          fifo_ptr  <= fifo_ptr + 1;
        end else bus_rdata <= mem[bus_addr];
      end
    end
  end

  // ---- behavioural reference model ----
  bit          q_acc[$];
  bit          q_sel[$];
  int          m_chain;
  logic [31:0] m_latch;
  bit          m_req, m_wr, m_pend;
  int          m_addr;
  logic [31:0] m_wdata;

  always @(posedge clk) begin
    if (rst) begin
      q_acc = {};
      for (int i = 0; i < FW; i++) q_acc.push_back(1'b0);
      q_sel = {};
      for (int i = 0; i < 5; i++) q_sel.push_back(1'b0);
      m_chain = 31; m_latch = 0; m_req = 0; m_wr = 0; m_pend = 0;
      m_addr = 0; m_wdata = 0;
    end else begin
      automatic logic [31:0] old_latch = m_latch;
      automatic int  old_chain = m_chain;
      automatic bit  old_req = m_req;
      automatic bit  old_wr = m_wr;
      automatic bit  old_pend = m_pend;
      automatic bit  act = (tap_ir == 4'hC) && (old_chain == 0);
      automatic bit  sel = (tap_ir == 4'h2);
      m_pend = old_req && !old_wr;
      if (old_pend) m_latch = bus_rdata;
      m_req = 0;
      if (tap_capture) begin
        if (act) begin
          q_acc = {};
          for (int i = 0; i < DW; i++) q_acc.push_back(old_latch[i]);
          for (int i = 0; i < AW + 1; i++) q_acc.push_back(1'b0);
        end
        if (sel) begin
          q_sel = {};
          for (int i = 0; i < 5; i++) q_sel.push_back(old_chain[i]);
        end
      end else if (tap_shift) begin
        if (act) begin q_acc.push_back(tdi); void'(q_acc.pop_front()); end
        if (sel) begin q_sel.push_back(tdi); void'(q_sel.pop_front()); end
      end else if (tap_update) begin
        if (act) begin
          m_req = 1; m_wr = q_acc[FW-1];
          m_addr = 0; m_wdata = 0;
          for (int i = 0; i < AW; i++) m_addr += int'(q_acc[DW+i]) << i;
          for (int i = 0; i < DW; i++) m_wdata[i] = q_acc[i];
        end
        if (sel) begin
          m_chain = 0;
          for (int i = 0; i < 5; i++) m_chain += int'(q_sel[i]) << i;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      automatic bit exp_tdo;
      if (tap_ir == 4'h2) exp_tdo = q_sel[0];
      else if (tap_ir == 4'hC && m_chain == 0) exp_tdo = q_acc[0];
      else exp_tdo = 1'b0;
      chk(bus_req == m_req, "R6 access strobe", 64'(bus_req), 64'(m_req));
      if (m_req) begin
        chk(bus_wr == m_wr, "R2 direction", 64'(bus_wr), 64'(m_wr));
        chk(int'(bus_addr) == m_addr, "R2 address", 64'(bus_addr), 64'(m_addr));
        if (m_wr) chk(bus_wdata == m_wdata, "R2 write data", 64'(bus_wdata), 64'(m_wdata));
      end
      chk(tdo == exp_tdo, "R10 tdo", 64'(tdo), 64'(exp_tdo));
    end
  end

  // ---- scan helpers ----
  task automatic scan(input int len, input logic [FW-1:0] din, output logic [FW-1:0] dout);
    dout = '0;
    @(negedge clk); tap_capture = 1'b1;
    @(negedge clk); tap_capture = 1'b0;
    for (int i = 0; i < len; i++) begin
      tap_shift = 1'b1; tdi = din[i]; dout[i] = tdo;
      @(negedge clk);
    end
    tap_shift = 1'b0; tdi = 1'b0; tap_update = 1'b1;
    @(negedge clk); tap_update = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [FW-1:0] frm(input bit wr, input int addr, input logic [31:0] d);
    return {wr, 7'(addr), d};
  endfunction

  task automatic select_chain(input int ch, output logic [FW-1:0] d);
    tap_ir = 4'h2;
    scan(5, FW'(ch), d);
    tap_ir = 4'hC;
  endtask

  initial begin
    automatic logic [FW-1:0] d;
    automatic int rq;
    repeat (3) @(negedge clk);
    chk(tdo == 1'b0, "R9 tdo in reset", 64'(tdo), 0);
    chk(bus_req == 1'b0, "R9 req in reset", 64'(bus_req), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b0, "R9 req after reset", 64'(bus_req), 0);

    // R7: access code but chain still all ones -> no access, tdo quiet
    tap_ir = 4'hC; rq = n_req;
    scan(FW, frm(1, 9, 32'hDEAD_0000), d);
    chk(n_req == rq, "R7 unselected chain no access", 64'(n_req), 64'(rq));
    chk(d == '0, "R10 unselected chain tdo", 64'(d), 0);

    // R8: capture shows reset chain number, update selects chain 0
    select_chain(0, d);
    chk(d[4:0] == 5'h1F, "R8 reset chain value", 64'(d[4:0]), 64'h1F);

    // R9: first read after reset returns zero data
    scan(FW, frm(1, 10, 32'hA5A5_1234), d);
    chk(d[31:0] == 32'h0, "R9 latch zero after reset", 64'(d[31:0]), 0);
    chk(mem[10] == 32'hA5A5_1234, "R2 write landed", 64'(mem[10]), 64'hA5A5_1234);

    // R3, R4: read 10, then dummy read 0 drains it
    scan(FW, frm(0, 10, 32'hFFFF_FFFF), d);
    scan(FW, frm(0, 0, 32'h0), d);
    chk(d[31:0] == 32'hA5A5_1234, "R3 read result next scan", 64'(d[31:0]), 64'hA5A5_1234);
    chk(d[39:32] == 8'h0, "R4 header zero", 64'(d[39:32]), 0);

    // R5: read 10, write 20, then read 0 -> still read-10 data
    scan(FW, frm(0, 10, 32'h0), d);
    scan(FW, frm(1, 20, 32'h0BAD_F00D), d);
    scan(FW, frm(0, 0, 32'h0), d);
    chk(d[31:0] == 32'hA5A5_1234, "R5 write keeps latch", 64'(d[31:0]), 64'hA5A5_1234);
    scan(FW, frm(0, 20, 32'h0), d);
    chk(d[31:0] == ID_VAL, "R4 dummy read result", 64'(d[31:0]), 64'(ID_VAL));
    scan(FW, frm(0, 0, 32'h0), d);
    chk(d[31:0] == 32'h0BAD_F00D, "R2 written value read back", 64'(d[31:0]), 64'h0BAD_F00D);

    // R6: stream register pops once per read
    scan(FW, frm(1, 4, 32'd100), d);
    scan(FW, frm(0, 4, 32'h0), d);
    scan(FW, frm(0, 4, 32'h0), d);
    chk(d[31:0] == 32'd100, "R6 stream first", 64'(d[31:0]), 100);
    scan(FW, frm(0, 4, 32'h0), d);
    chk(d[31:0] == 32'd101, "R6 stream second", 64'(d[31:0]), 101);
    scan(FW, frm(0, 0, 32'h0), d);
    chk(d[31:0] == 32'd102, "R6 stream drained", 64'(d[31:0]), 102);
    chk(fifo_ptr == 32'd103, "R6 pointer advanced once per read", 64'(fifo_ptr), 103);

    // R1: top address and extreme data bits
    scan(FW, frm(1, 127, 32'h8000_0001), d);
    chk(mem[127] == 32'h8000_0001, "R1 field positions", 64'(mem[127]), 64'h8000_0001);

    // R7, R10: other instruction, other chain
    tap_ir = 4'h0; rq = n_req;
    scan(FW, frm(1, 30, 32'h1111_1111), d);
    chk(n_req == rq && d == '0, "R7 other instruction", 64'(n_req), 64'(rq));
    select_chain(3, d);
    rq = n_req;
    scan(FW, frm(1, 30, 32'h1111_1111), d);
    chk(n_req == rq, "R7 other chain", 64'(n_req), 64'(rq));
    select_chain(0, d);
    chk(d[4:0] == 5'd3, "R8 capture current chain", 64'(d[4:0]), 3);
    chk(mem[30] == 32'h0101_0101 * 30, "R7 register untouched", 64'(mem[30]), 64'(32'h0101_0101 * 30));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule